// File: doc/BRIEF.md
# Accumulator Core with Single-Level Interrupt Entry

This block is a compact 16-bit accumulator processor. It repeats one cycle: fetch an instruction, execute it, then check for an interrupt. It shares one word-addressed synchronous memory for code, data and a downward-growing control stack. The top four bits of each instruction select the operation, and the low twelve bits give a memory address.

When interrupts are enabled and the request input is high at the check point, the core does four things. It acknowledges the request for one cycle, saves its status word and return address on the control stack, clears the enable bit and continues at a fixed handler address. A return instruction restores both words and brings the stack pointer back to where it started. Because entry clears the enable bit, interrupts are handled one after another and never nested. A halt instruction stops the core for good, until the next reset.

Top module: `acc_core`

## Requirements
- R1: While reset is high and just after it, `halted`, `mem_we` and `irq_ack` are 0 and `mem_addr` shows the reset program address (default 0x300). The accumulator and status word start at 0 and the stack pointer starts at 0xFFF.
- R2: Each fetch reads the word at the program counter into the instruction register and increments the program counter by one. One cycle after the fetch cycle, `mem_addr` shows the incremented value.
- R3: Opcode 0x1 (instruction bits 15:12) copies the word at the address in bits 11:0 into the accumulator.
- R4: Opcode 0x5 adds the addressed word to the accumulator modulo 2^16 and sets the overflow flag (status bit 1) to the signed-overflow result. Only this opcode changes the overflow flag.
- R5: Opcode 0x2 writes the accumulator to the addressed word. It is the only instruction whose execution drives `mem_we`.
- R6: Opcode 0x0 raises `halted`, which stays high. No memory write happens while `halted` is high.
- R7: Opcode 0xE sets and opcode 0xD clears the interrupt-enable flag (status bit 0). While that flag is 0, a high `irq` is ignored: no acknowledge, and the program result is unchanged.
- R8: With the enable flag set, the request is checked only after an instruction completes. Taking it has these effects, in order:
  - `irq_ack` pulses for one cycle.
  - The status word is written at 0xFFF, then the return address (the address of the next instruction) at 0xFFE, leaving the stack pointer two lower.
  - The program counter becomes the handler address (default 0x100) and the enable flag is cleared, so a request held high during the handler is not taken again.
- R9: Opcode 0xF with address 0 reads back the return address and the status word from the stack and restores both. The stack pointer returns to its value before entry, so a later entry saves to the same two words.
- R10: The program 0x1940, 0x5941, 0x2941, 0x0000 at 0x300, with 3 at 0x940 and 2 at 0x941, leaves 5 at 0x941.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| irq | input | 1 | Interrupt request, level sensitive |
| irq_ack | output | 1 | One-cycle acknowledge of a taken interrupt |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Load-add-store programs run on both random and directed operand pairs. The directed pairs include 0x7FFF+1, 0x8000+0x8000 and 0xFFFF+1, which separate wrap-around from signed overflow.

The request arrives at a random cycle within the program. The saved return address then shows which instruction boundary the entry fell on. The value the handler stores and the saved status word must match that boundary exactly, which separates correct resumption from a skipped or repeated instruction.

Directed runs cover further cases:
- A request held high while interrupts are disabled, or disabled again after enabling, must never be acknowledged.
- A request held high through the handler checks that entries are not nested.
- Two back-to-back entries check that the return restores the stack pointer, since the second entry must save to the same two words.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int OP_W   = WORD_W - ADDR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam logic [OP_W-1:0] OP_HALT  = 4'h0;
    localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
    localparam logic [OP_W-1:0] OP_STORE = 4'h2;
    localparam logic [OP_W-1:0] OP_ADD   = 4'h5;
    localparam logic [OP_W-1:0] OP_DI    = 4'hD;
    localparam logic [OP_W-1:0] OP_EI    = 4'hE;
    localparam logic [OP_W-1:0] OP_RETI  = 4'hF;

    typedef struct packed {
        logic [OP_W-1:0] op;
        addr_t           addr;
    } instr_t;

    // Status word: bit 0 interrupt enable, bit 1 signed overflow.
    typedef struct packed {
        logic [WORD_W-3:0] rsvd;
        logic              ovf;
        logic              ie;
    } status_t;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_WBACK,
        ST_INTCHK,
        ST_PUSH_SW,
        ST_PUSH_PC,
        ST_VECTOR,
        ST_POP_A,
        ST_POP_B,
        ST_POP_C,
        ST_HALT
    } state_e;

    function automatic logic signed_ovf(input word_t a, input word_t b, input word_t s);
        return (a[WORD_W-1] == b[WORD_W-1]) && (s[WORD_W-1] != a[WORD_W-1]);
    endfunction

endpackage

// File: rtl/acc_core_alu.sv
module acc_core_alu
    import acc_core_pkg::*;
(
    input  word_t acc,
    input  word_t operand,
    input  logic  do_add,
    output word_t result,
    output logic  ovf
);
    word_t sum;

    always_comb begin
        sum    = acc + operand;
        ovf    = signed_ovf(acc, operand, sum);
        result = do_add ? sum : operand;
    end
endmodule

// File: rtl/acc_core_stack.sv
module acc_core_stack #(
    parameter int             AW   = 12,
    parameter logic [AW-1:0]  INIT = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] sp
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst)       sp <= INIT;
        else if (push) sp <= sp - ONE;
        else if (pop)  sp <= sp + ONE;
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC  = 12'h300,
    parameter logic [ADDR_W-1:0] VECTOR_PC = 12'h100,
    parameter logic [ADDR_W-1:0] SP_INIT   = 12'hFFF
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              irq,
    output logic              irq_ack,
    output logic              halted
);
    localparam int PAD_W = WORD_W - ADDR_W;

    state_e  state_q, state_d;
    addr_t   pc_q, pc_d;
    instr_t  ir_q, ir_d;
    word_t   acc_q, acc_d;
    status_t sts_q, sts_d;
    addr_t   sp;
    logic    sp_push, sp_pop;
    word_t   alu_res;
    logic    alu_ovf;

    acc_core_alu u_alu (
        .acc     (acc_q),
        .operand (mem_rdata),
        .do_add  (ir_q.op == OP_ADD),
        .result  (alu_res),
        .ovf     (alu_ovf)
    );

    acc_core_stack #(.AW(ADDR_W), .INIT(SP_INIT)) u_stack (
        .clk  (clk),
        .rst  (rst),
        .push (sp_push),
        .pop  (sp_pop),
        .sp   (sp)
    );

    always_comb begin
        state_d   = state_q;
        pc_d      = pc_q;
        ir_d      = ir_q;
        acc_d     = acc_q;
        sts_d     = sts_q;
        mem_addr  = pc_q;
        mem_wdata = '0;
        mem_we    = 1'b0;
        irq_ack   = 1'b0;
        sp_push   = 1'b0;
        sp_pop    = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                pc_d    = pc_q + 1'b1;
                state_d = ST_DECODE;
            end
            ST_DECODE: begin
                ir_d    = instr_t'(mem_rdata);
                state_d = ST_EXEC;
            end
            ST_EXEC: begin
                mem_addr = ir_q.addr;
                state_d  = ST_INTCHK;
                case (ir_q.op)
                    OP_LOAD, OP_ADD: state_d = ST_WBACK;
                    OP_STORE: begin
                        mem_we    = 1'b1;
                        mem_wdata = acc_q;
                    end
                    OP_HALT: state_d = ST_HALT;
                    OP_EI:   sts_d.ie = 1'b1;
                    OP_DI:   sts_d.ie = 1'b0;
                    OP_RETI: begin
                        if (ir_q.addr == '0) begin
                            sp_pop  = 1'b1;
                            state_d = ST_POP_A;
                        end
                    end
                    default: state_d = ST_INTCHK;
                endcase
            end
            ST_WBACK: begin
                mem_addr = ir_q.addr;
                acc_d    = alu_res;
                if (ir_q.op == OP_ADD) sts_d.ovf = alu_ovf;
                state_d  = ST_INTCHK;
            end
            ST_INTCHK: begin
                if (sts_q.ie && irq) begin
                    irq_ack = 1'b1;
                    state_d = ST_PUSH_SW;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_PUSH_SW: begin
                mem_addr  = sp;
                mem_we    = 1'b1;
                mem_wdata = word_t'(sts_q);
                sp_push   = 1'b1;
                state_d   = ST_PUSH_PC;
            end
            ST_PUSH_PC: begin
                mem_addr  = sp;
                mem_we    = 1'b1;
                mem_wdata = {{PAD_W{1'b0}}, pc_q};
                sp_push   = 1'b1;
                state_d   = ST_VECTOR;
            end
            ST_VECTOR: begin
                pc_d     = VECTOR_PC;
                sts_d.ie = 1'b0;
                state_d  = ST_FETCH;
            end
            ST_POP_A: begin
                mem_addr = sp;
                sp_pop   = 1'b1;
                state_d  = ST_POP_B;
            end
            ST_POP_B: begin
                mem_addr = sp;
                pc_d     = mem_rdata[ADDR_W-1:0];
                state_d  = ST_POP_C;
            end
            ST_POP_C: begin
                sts_d      = status_t'(mem_rdata);
                sts_d.rsvd = '0;
                state_d    = ST_INTCHK;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= RESET_PC;
            ir_q    <= '0;
            acc_q   <= '0;
            sts_q   <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            ir_q    <= ir_d;
            acc_q   <= acc_d;
            sts_q   <= sts_d;
        end
    end

    assign halted = (state_q == ST_HALT);

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_core_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VECTOR_PC = 12'h100
) (
    input logic   clk,
    input logic   rst,
    input logic   irq,
    input logic   irq_ack,
    input logic   halted,
    input logic   mem_we,
    input addr_t  pc,
    input addr_t  sp,
    input logic   ie,
    input state_e state
);
    // R6: halt is permanent until reset
    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R6: nothing is written while halted
    a_r6_no_write_halted: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    // R7: acknowledge only with the enable flag set and a request present
    a_r7_ack_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (ie && irq));

    // R8: the save writes start the cycle after the acknowledge
    a_r8_push_follows_ack: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> mem_we);

    // R8: acknowledge is a single-cycle pulse
    a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);

    // R8: two words saved, stack pointer two lower
    a_r8_sp_two_down: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> ##3 (sp == $past(sp, 3) - 12'd2));

    // R8: handler entry with interrupts disabled
    a_r8_vector_entry: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> ##4 ((pc == VECTOR_PC) && !ie));

    // R2: the program counter steps by one on every fetch
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (pc == $past(pc) + 12'd1));
endmodule

bind acc_core acc_core_chk #(.VECTOR_PC(VECTOR_PC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq     (irq),
    .irq_ack (irq_ack),
    .halted  (halted),
    .mem_we  (mem_we),
    .pc      (pc_q),
    .sp      (sp),
    .ie      (sts_q.ie),
    .state   (state_q)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        irq = 1'b0;
    logic        irq_ack;
    logic        halted;

    logic [15:0] mem [0:4095];
    int checks = 0;
    int errors = 0;
    int ack_cnt = 0, we_cnt = 0, wr200 = 0, trig_a = 0, trig_b = 0, wd_cyc = 0;

    always #5 clk = ~clk;

    acc_core u_acc_core (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .irq(irq),
        .irq_ack(irq_ack), .halted(halted)
    );

    // synchronous memory, one cycle read latency
    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] = mem_wdata;
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (irq_ack) ack_cnt++;
            if (mem_we) begin
                we_cnt++;
                if (mem_addr == 12'h200) wr200++;
                if (mem_addr == 12'h942) trig_a++;
                if (mem_addr == 12'h943) trig_b++;
            end
        end
    end

    always @(posedge clk) begin
        wd_cyc++;
        if (wd_cyc > 150000) begin
            $display("FAIL watchdog expired actual=%0d expected<=150000", wd_cyc);
            $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
            $finish;
        end
    end

    function automatic logic [15:0] exp_sum(input logic [15:0] a, input logic [15:0] b);
        return a + b;
    endfunction

    function automatic logic exp_ovf(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] s;
        s = a + b;
        return (a[15] == b[15]) && (s[15] != a[15]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        mem[12'h100] = 16'h2200;   // handler: store acc to 0x200
        mem[12'h101] = 16'hF000;   // return from interrupt
    endtask

    task automatic do_reset();
        irq = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // runs until halt; irq raised at cycle raise_at, or on stores to 0x942/0x943 when trig
    task automatic run_prog(input int raise_at, input bit trig, input bit hold, output int acks);
        int pack, pa, pb, p200;
        bit done;
        pack = ack_cnt; pa = trig_a; pb = trig_b; p200 = wr200;
        acks = ack_cnt;
        done = 1'b0;
        for (int c = 1; c <= 600; c++) begin
            @(negedge clk);
            if (c == raise_at) irq = 1'b1;
            if (trig && (trig_a != pa || trig_b != pb)) irq = 1'b1;
            pa = trig_a; pb = trig_b;
            if (ack_cnt != pack) begin
                pack = ack_cnt;
                if (!hold) irq = 1'b0;
            end
            if (hold && wr200 != p200) begin
                p200 = wr200;
                irq = 1'b0;
            end
            if (halted) begin
                done = 1'b1;
                break;
            end
        end
        acks = ack_cnt - acks;
        irq = 1'b0;
        chk("R6 program reached halt", {31'b0, done}, 32'd1);
    endtask

    initial begin
        int acks, w0;
        logic [15:0] a, b, ret, cap, sw, exp_cap, exp_sw;

        void'($urandom(32'h5EED_1234));
        clear_mem();

        // ---- R1 reset state
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 halted in reset", {31'b0, halted}, 32'd0);
        chk("R1 we in reset", {31'b0, mem_we}, 32'd0);
        chk("R1 ack in reset", {31'b0, irq_ack}, 32'd0);
        chk("R1 reset pc on bus", {20'b0, mem_addr}, 32'h300);

        // ---- R10 reference program, R2 fetch stepping
        clear_mem();
        mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941;
        mem[12'h302] = 16'h2941; mem[12'h303] = 16'h0000;
        mem[12'h940] = 16'd3;    mem[12'h941] = 16'd2;
        do_reset();
        chk("R1 first fetch address", {20'b0, mem_addr}, 32'h300);
        @(negedge clk);
        chk("R2 pc incremented after fetch", {20'b0, mem_addr}, 32'h301);
        w0 = we_cnt;
        run_prog(-1, 1'b0, 1'b0, acks);
        chk("R10 reference result", {16'b0, mem[12'h941]}, 32'd5);
        chk("R3 source operand untouched", {16'b0, mem[12'h940]}, 32'd3);
        chk("R5 single write by store", we_cnt - w0, 32'd1);
        w0 = we_cnt;
        repeat (20) @(negedge clk);
        chk("R6 no writes after halt", we_cnt - w0, 32'd0);
        chk("R6 halted stays high", {31'b0, halted}, 32'd1);

        // ---- R3 load then store
        clear_mem();
        mem[12'h300] = 16'h1940; mem[12'h301] = 16'h2950; mem[12'h302] = 16'h0000;
        mem[12'h940] = 16'hBEEF;
        do_reset();
        run_prog(-1, 1'b0, 1'b0, acks);
        chk("R3 load copies word", {16'b0, mem[12'h950]}, 32'hBEEF);

        // ---- R7 disabled interrupts ignored
        clear_mem();
        mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941;
        mem[12'h302] = 16'h2942; mem[12'h303] = 16'h0000;
        mem[12'h940] = 16'h1111; mem[12'h941] = 16'h2222;
        do_reset();
        run_prog(1, 1'b0, 1'b1, acks);
        chk("R7 no ack while disabled", acks, 32'd0);
        chk("R7 result unaffected", {16'b0, mem[12'h942]}, 32'h3333);

        clear_mem();
        mem[12'h300] = 16'hE000; mem[12'h301] = 16'hD000; mem[12'h302] = 16'h1940;
        mem[12'h303] = 16'h5941; mem[12'h304] = 16'h2942; mem[12'h305] = 16'h0000;
        mem[12'h940] = 16'h0005; mem[12'h941] = 16'h0006;
        do_reset();
        run_prog(12, 1'b0, 1'b1, acks);
        chk("R7 disable after enable blocks ack", acks, 32'd0);
        chk("R7 result after disable", {16'b0, mem[12'h942]}, 32'd11);

        // ---- R8/R9/R4 two entries triggered by stores, overflow case
        clear_mem();
        mem[12'h300] = 16'hE000; mem[12'h301] = 16'h1940; mem[12'h302] = 16'h5941;
        mem[12'h303] = 16'h2942; mem[12'h304] = 16'h1940; mem[12'h305] = 16'h2943;
        mem[12'h306] = 16'h0000;
        mem[12'h940] = 16'h7FFF; mem[12'h941] = 16'h0001;
        mem[12'hFFC] = 16'hA5A5; mem[12'hFFD] = 16'hA5A5;
        do_reset();
        run_prog(-1, 1'b1, 1'b0, acks);
        chk("R8 two entries taken", acks, 32'd2);
        chk("R4 wrapped sum", {16'b0, mem[12'h942]}, 32'h8000);
        chk("R8 second return address", {16'b0, mem[12'hFFE]}, 32'h0306);
        chk("R4 overflow flag in saved status", {16'b0, mem[12'hFFF]}, 32'h0003);
        chk("R9 stack restored, no deeper save", {16'b0, mem[12'hFFD]}, 32'hA5A5);
        chk("R9 stack restored, slot 0xFFC", {16'b0, mem[12'hFFC]}, 32'hA5A5);
        chk("R8 handler saw accumulator", {16'b0, mem[12'h200]}, 32'h7FFF);
        chk("R9 resumed program completed", {16'b0, mem[12'h943]}, 32'h7FFF);

        // ---- R8 no nesting: request held through handler
        clear_mem();
        mem[12'h300] = 16'hE000; mem[12'h301] = 16'h1940; mem[12'h302] = 16'h5941;
        mem[12'h303] = 16'h2942; mem[12'h304] = 16'h0000;
        mem[12'h940] = 16'h0100; mem[12'h941] = 16'h0023;
        do_reset();
        run_prog(7, 1'b0, 1'b1, acks);
        chk("R8 held request taken once", acks, 32'd1);
        chk("R9 result after held request", {16'b0, mem[12'h942]}, 32'h0123);

        // ---- random operands and request timing
        for (int it = 0; it < 24; it++) begin
            int t;
            case (it)
                0: begin a = 16'h7FFF; b = 16'h0001; end
                1: begin a = 16'h8000; b = 16'h8000; end
                2: begin a = 16'hFFFF; b = 16'h0001; end
                default: begin a = 16'($urandom); b = 16'($urandom); end
            endcase
            t = $urandom_range(1, 24);
            clear_mem();
            mem[12'h300] = 16'hE000; mem[12'h301] = 16'h1940; mem[12'h302] = 16'h5941;
            mem[12'h303] = 16'h2942; mem[12'h304] = 16'h0000;
            mem[12'h940] = a; mem[12'h941] = b;
            do_reset();
            run_prog(t, 1'b0, 1'b0, acks);
            chk("R4 random sum", {16'b0, mem[12'h942]}, {16'b0, exp_sum(a, b)});
            if (acks == 1) begin
                ret = mem[12'hFFE];
                cap = mem[12'h200];
                sw  = mem[12'hFFF];
                chk("R8 return at instruction boundary",
                    {31'b0, (ret >= 16'h0301 && ret <= 16'h0304)}, 32'd1);
                exp_cap = (ret == 16'h0301) ? 16'h0000 :
                          (ret == 16'h0302) ? a : exp_sum(a, b);
                exp_sw  = {14'b0, (ret >= 16'h0303) && exp_ovf(a, b), 1'b1};
                chk("R8 accumulator at entry", {16'b0, cap}, {16'b0, exp_cap});
                chk("R8 saved status word", {16'b0, sw}, {16'b0, exp_sw});
            end else begin
                chk("R8 at most one entry", {31'b0, acks == 0}, 32'd1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule